// File: doc/BRIEF.md
# Instruction Prefetch Queue with Zero-Cycle Branch Folding

This block sits between instruction fetch and execution. It requests 32-bit instruction words from a fetch port with a fixed one-cycle response latency, buffers up to four of them, and hands them in program order to the execution side through a one-entry issue stage. Branch words are caught when they come back from fetch. They never enter the queue and never take an issue cycle: the branch logic consumes them and redirects the fetch address when needed.

Unconditional branches always redirect. A conditional branch whose condition is already settled (`cond_busy_i` low) is decided at once from `cond_value_i`. If the condition is still being computed, a static guess is taken from the hint bit carried in the branch word, and fetch follows the guessed stream. Words fetched past that guess are tagged speculative. They may sit in the queue and in the issue stage, but they are not offered to execution until `resolve_valid_i` arrives. A correct guess clears every tag in one cycle. A wrong guess removes every tagged word and restarts fetch on the other path. Only one guess may be outstanding at a time. A second conditional branch met during that time parks fetch, and fetch later restarts at that branch's own address.

Top module: `pfq_fold_unit`

## Requirements
- R1: After reset, `fetch_req_o` is 1 with `fetch_addr_o` equal to `RESET_ADDR`, and `issue_valid_o` is 0.
- R2: Non-branch words reach the issue port in fetch order. Fetch addresses step by 4 between redirects, and no word is lost or duplicated while `issue_ready_i` is high.
- R3: At most `DEPTH` words are buffered in the queue. `fetch_req_o` is low whenever the queued words plus the request in flight reach `DEPTH`, and no word is dropped by a full queue.
- R4: A word is a branch when bits [31:25] equal 7'b1011000 (unconditional) or 7'b1100000 (conditional). Branch words never appear on the issue port.
- R5: A taken branch at address A redirects fetch to A + (sign-extended bits [23:0] shifted left by 2). Negative displacements move backwards.
- R6: When `cond_busy_i` is 0, a conditional branch is taken exactly when `cond_value_i` is 1. The hint bit is ignored and nothing becomes speculative.
- R7: When `cond_busy_i` is 1, a conditional branch is predicted taken when bit [24] is 1 and not taken when it is 0, and fetch continues down the predicted path.
- R8: Words fetched after a prediction are not presented on the issue port (`issue_valid_o` stays 0 for them) until the branch resolves.
- R9: A `resolve_valid_i` pulse whose `resolve_taken_i` matches the prediction clears all speculative tags at that edge. A held word is presented in the very next cycle, and issue continues in order.
- R10: A resolve pulse that contradicts the prediction discards every speculative word from the queue and the issue stage. The next fetch request goes to the path that was not predicted.
- R11: The fetch response arriving in the cycle after any redirect or flush is discarded, so a wrong-path word never enters the queue.
- R12: A conditional branch met while a prediction is outstanding stops fetch (`fetch_req_o` low) until the resolve pulse. After a correct resolve, fetch restarts at that branch's address and the branch is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req_o | output | 1 | Fetch request this cycle |
| fetch_addr_o | output | 32 | Address of the requested word |
| fetch_rvalid_i | input | 1 | Response valid, one cycle after the request |
| fetch_rdata_i | input | 32 | Returned instruction word |
| issue_valid_o | output | 1 | Non-speculative instruction offered to execution |
| issue_instr_o | output | 32 | Instruction word offered |
| issue_ready_i | input | 1 | Execution accepts the offered word |
| cond_busy_i | input | 1 | Branch condition still being produced by execution |
| cond_value_i | input | 1 | Branch condition value when not busy (1 = take) |
| resolve_valid_i | input | 1 | Pulse: the outstanding predicted branch is now decided |
| resolve_taken_i | input | 1 | Actual direction of the outstanding branch |

## Verification
The assertions assume that the fetch side answers each request exactly one cycle later, and that a resolve pulse comes only while a prediction is outstanding. A pulse at any other time is ignored by design. The bench memory model records each request on the falling edge and returns the stored word one cycle later, with no extra or missing responses. Resolve pulses are driven for a single cycle, and only after the issue port has gone quiet behind a predicted branch. The condition inputs are held steady around each branch, so each scenario gives one defined outcome that the bench can predict.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned DISP_W   = 24;
    localparam int unsigned HINT_BIT = 24;
    localparam int unsigned OPC_LSB  = 25;
    localparam int unsigned OPC_W    = WORD_W - OPC_LSB;

    localparam logic [OPC_W-1:0] OPC_JUMP  = 7'b1011000;
    localparam logic [OPC_W-1:0] OPC_CJUMP = 7'b1100000;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t word;
        logic  spec;
    } slot_t;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_JUMP = 2'd1,
        BR_COND = 2'd2
    } br_kind_e;

    function automatic br_kind_e classify(input word_t w);
        if (w[WORD_W-1:OPC_LSB] == OPC_JUMP)       return BR_JUMP;
        else if (w[WORD_W-1:OPC_LSB] == OPC_CJUMP) return BR_COND;
        else                                       return BR_NONE;
    endfunction

    function automatic word_t branch_target(input word_t pc, input word_t w);
        return pc + {{(WORD_W-DISP_W-2){w[DISP_W-1]}}, w[DISP_W-1:0], 2'b00};
    endfunction

endpackage

// File: rtl/pfq_queue.sv
module pfq_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  slot_t            push_slot_i,
    input  logic             pop_i,
    input  logic             flush_spec_i,
    input  logic             clear_spec_i,
    output slot_t            head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             any_spec_o
);

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic [CNT_W-1:0]  count;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [CNT_W-1:0] keep_d;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        st_d   = st_q;
        keep_d = '0;
        cnt_d  = st_q.count;
        if (flush_spec_i) begin
            // speculative entries are always the youngest, so the survivors are a prefix
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) < st_q.count && !st_q.slots[i].spec) begin
                    keep_d = keep_d + 1'b1;
                end
            end
            st_d.count = keep_d;
        end else begin
            if (pop_i) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.slots[i] = st_q.slots[i+1];
                end
                cnt_d = st_q.count - 1'b1;
            end
            if (push_i) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == cnt_d) begin
                        st_d.slots[i] = push_slot_i;
                    end
                end
                cnt_d = cnt_d + 1'b1;
            end
            st_d.count = cnt_d;
        end
        if (clear_spec_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.slots[i].spec = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        any_spec_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < st_q.count && st_q.slots[i].spec) begin
                any_spec_o = 1'b1;
            end
        end
    end

    assign head_o  = st_q.slots[0];
    assign count_o = st_q.count;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> (st_q.count < CNT_W'(DEPTH)));

    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.count != '0));

    assert_flush_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_spec_i |-> (!push_i && !pop_i));

endmodule

// File: rtl/pfq_branch.sv
module pfq_branch
    import pfq_pkg::*;
(
    input  logic  valid_i,
    input  word_t word_i,
    input  word_t addr_i,
    input  logic  cond_busy_i,
    input  logic  cond_value_i,
    input  logic  pred_busy_i,
    output logic  is_branch_o,
    output logic  redirect_o,
    output word_t redirect_addr_o,
    output logic  predict_o,
    output logic  pred_taken_o,
    output word_t alt_addr_o,
    output logic  halt_o
);

    br_kind_e kind;
    word_t    target;
    word_t    seq_addr;

    assign kind     = classify(word_i);
    assign target   = branch_target(addr_i, word_i);
    assign seq_addr = addr_i + 32'd4;

    always_comb begin
        is_branch_o     = 1'b0;
        redirect_o      = 1'b0;
        redirect_addr_o = target;
        predict_o       = 1'b0;
        pred_taken_o    = 1'b0;
        alt_addr_o      = seq_addr;
        halt_o          = 1'b0;
        if (valid_i) begin
            unique case (kind)
                BR_JUMP: begin
                    is_branch_o = 1'b1;
                    redirect_o  = 1'b1;
                end
                BR_COND: begin
                    is_branch_o = 1'b1;
                    if (pred_busy_i) begin
                        halt_o = 1'b1;
                    end else if (!cond_busy_i) begin
                        redirect_o = cond_value_i;
                    end else begin
                        predict_o    = 1'b1;
                        pred_taken_o = word_i[HINT_BIT];
                        redirect_o   = word_i[HINT_BIT];
                        alt_addr_o   = word_i[HINT_BIT] ? seq_addr : target;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pfq_fold_unit.sv
module pfq_fold_unit
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH      = 4,
    parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        fetch_req_o,
    output logic [31:0] fetch_addr_o,
    input  logic        fetch_rvalid_i,
    input  logic [31:0] fetch_rdata_i,
    output logic        issue_valid_o,
    output logic [31:0] issue_instr_o,
    input  logic        issue_ready_i,
    input  logic        cond_busy_i,
    input  logic        cond_value_i,
    input  logic        resolve_valid_i,
    input  logic        resolve_taken_i
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        word_t fetch_pc;
        logic  pend;
        word_t pend_addr;
        logic  drop;
        logic  spec_active;
        logic  pred_taken;
        word_t alt_addr;
        logic  halt;
        word_t refetch_addr;
        logic  iss_valid;
        slot_t iss;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             resolve_now, mispredict, confirm;
    logic             resp_ok, fire, q_push, q_pop, q_any_spec;
    slot_t            q_head, push_slot;
    logic [CNT_W-1:0] q_count;
    logic [CNT_W:0]   credit_used;

    logic  br_is_branch, br_redirect, br_predict, br_pred_taken, br_halt;
    word_t br_addr, br_alt;

    assign resolve_now = resolve_valid_i && st_q.spec_active;
    assign mispredict  = resolve_now && (resolve_taken_i != st_q.pred_taken);
    assign confirm     = resolve_now && !mispredict;
    assign resp_ok     = fetch_rvalid_i && !st_q.drop && !st_q.halt && !mispredict;

    pfq_branch u_branch (
        .valid_i        (resp_ok),
        .word_i         (fetch_rdata_i),
        .addr_i         (st_q.pend_addr),
        .cond_busy_i    (cond_busy_i),
        .cond_value_i   (cond_value_i),
        .pred_busy_i    (st_q.spec_active && !confirm),
        .is_branch_o    (br_is_branch),
        .redirect_o     (br_redirect),
        .redirect_addr_o(br_addr),
        .predict_o      (br_predict),
        .pred_taken_o   (br_pred_taken),
        .alt_addr_o     (br_alt),
        .halt_o         (br_halt)
    );

    assign q_push         = resp_ok && !br_is_branch;
    assign push_slot.word = fetch_rdata_i;
    assign push_slot.spec = st_q.spec_active && !confirm;

    assign credit_used = {1'b0, q_count} + {{CNT_W{1'b0}}, st_q.pend};
    assign fetch_req_o  = !st_q.halt && (credit_used < (CNT_W+1)'(DEPTH));
    assign fetch_addr_o = st_q.fetch_pc;

    assign issue_valid_o = st_q.iss_valid && !st_q.iss.spec;
    assign issue_instr_o = st_q.iss.word;
    assign fire          = issue_valid_o && issue_ready_i;

    always_comb begin
        st_d = st_q;

        // fetch sequencing
        st_d.pend = fetch_req_o;
        st_d.drop = 1'b0;
        if (fetch_req_o) begin
            st_d.pend_addr = st_q.fetch_pc;
            st_d.fetch_pc  = st_q.fetch_pc + 32'd4;
        end

        // resolution of the outstanding prediction
        if (confirm) begin
            st_d.spec_active = 1'b0;
            if (st_q.halt) begin
                st_d.halt     = 1'b0;
                st_d.fetch_pc = st_q.refetch_addr;
                st_d.drop     = 1'b1;
            end
        end
        if (mispredict) begin
            st_d.spec_active = 1'b0;
            st_d.halt        = 1'b0;
            st_d.fetch_pc    = st_q.alt_addr;
            st_d.drop        = 1'b1;
        end

        // branch folding on the returning word
        if (br_redirect) begin
            st_d.fetch_pc = br_addr;
            st_d.drop     = 1'b1;
        end
        if (br_predict) begin
            st_d.spec_active = 1'b1;
            st_d.pred_taken  = br_pred_taken;
            st_d.alt_addr    = br_alt;
        end
        if (br_halt) begin
            st_d.halt         = 1'b1;
            st_d.refetch_addr = st_q.pend_addr;
            st_d.drop         = 1'b1;
        end

        // issue stage
        if (mispredict && st_q.iss.spec) begin
            st_d.iss_valid = 1'b0;
        end
        if (confirm) begin
            st_d.iss.spec = 1'b0;
        end
        if (fire) begin
            st_d.iss_valid = 1'b0;
        end
        q_pop = !mispredict && !st_d.iss_valid && (q_count != '0);
        if (q_pop) begin
            st_d.iss_valid = 1'b1;
            st_d.iss.word  = q_head.word;
            st_d.iss.spec  = q_head.spec && !confirm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.fetch_pc <= RESET_ADDR;
        end else begin
            st_q <= st_d;
        end
    end

    pfq_queue #(.DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (q_push),
        .push_slot_i (push_slot),
        .pop_i       (q_pop),
        .flush_spec_i(mispredict),
        .clear_spec_i(confirm),
        .head_o      (q_head),
        .count_o     (q_count),
        .any_spec_o  (q_any_spec)
    );

    assert_stall_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !fetch_req_o);

    assert_no_branch_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (classify(issue_instr_o) == BR_NONE));

    assert_redirect_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        br_redirect |=> (fetch_addr_o == $past(br_addr)));

    assert_confirm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        confirm |=> (!q_any_spec && !(st_q.iss_valid && st_q.iss.spec)));

    assert_flush_spec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> (!q_any_spec && !(st_q.iss_valid && st_q.iss.spec)));

    assert_single_pred_R12: assert property (@(posedge clk) disable iff (!rst_n)
        br_predict |-> (!st_q.spec_active || confirm));

    assert_halt_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt && !resolve_valid_i) |=> (st_q.halt && !fetch_req_o));

endmodule

// File: tb/pfq_fold_unit_bench.sv
`timescale 1ns/1ps
module pfq_fold_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        rsp_v = 1'b0;
    logic [31:0] rsp_d = '0;
    logic        issue_valid;
    logic [31:0] issue_instr;
    logic        issue_ready = 1'b0;
    logic        cond_busy = 1'b0;
    logic        cond_value = 1'b0;
    logic        res_v = 1'b0;
    logic        res_t = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] prog [64];
    logic [31:0] log_w [64];
    int          log_n = 0;
    int          br_issued = 0;
    int          exp_a [16];

    always #2.5 clk = ~clk;

    pfq_fold_unit u_pfq_fold_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_req_o    (fetch_req),
        .fetch_addr_o   (fetch_addr),
        .fetch_rvalid_i (rsp_v),
        .fetch_rdata_i  (rsp_d),
        .issue_valid_o  (issue_valid),
        .issue_instr_o  (issue_instr),
        .issue_ready_i  (issue_ready),
        .cond_busy_i    (cond_busy),
        .cond_value_i   (cond_value),
        .resolve_valid_i(res_v),
        .resolve_taken_i(res_t)
    );

    function automatic logic [31:0] plain(input int a);
        return 32'h1000_0000 | 32'(a);
    endfunction

    function automatic logic [31:0] jump(input logic [23:0] d);
        return {7'b1011000, 1'b0, d};
    endfunction

    function automatic logic [31:0] cjump(input logic h, input logic [23:0] d);
        return {7'b1100000, h, d};
    endfunction

    // memory model: one-cycle response latency
    initial begin
        logic        pend;
        logic [31:0] pend_a;
        pend = 1'b0;
        pend_a = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend  = 1'b0;
                rsp_v = 1'b0;
            end else begin
                rsp_v  = pend;
                rsp_d  = prog[pend_a[7:2]];
                pend   = fetch_req;
                pend_a = fetch_addr;
            end
        end
    end

    // issue monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && issue_valid && issue_ready) begin
                if (issue_instr[31:28] == 4'hB || issue_instr[31:28] == 4'hC) br_issued++;
                if (log_n < 64) log_w[log_n] = issue_instr;
                log_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_plain();
        for (int i = 0; i < 64; i++) prog[i] = plain(i * 4);
    endtask

    task automatic do_reset(input logic ready);
        @(posedge clk); #1;
        rst_n = 1'b0;
        issue_ready = ready;
        res_v = 1'b0;
        res_t = 1'b0;
        for (int i = 0; i < 64; i++) log_w[i] = '0;
        log_n = 0;
        br_issued = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_issued(input int n);
        for (int k = 0; k < 300 && log_n < n; k++) @(negedge clk);
    endtask

    task automatic check_seq(input string tag, input int n);
        wait_issued(n);
        for (int i = 0; i < n; i++) begin
            check(log_w[i] == plain(exp_a[i]), tag, log_w[i], plain(exp_a[i]));
        end
        check(br_issued == 0, "R4 branch word reached issue port", 32'(br_issued), 32'd0);
    endtask

    task automatic pulse_resolve(input logic taken);
        @(posedge clk); #1;
        res_v = 1'b1;
        res_t = taken;
        @(posedge clk); #1;
        res_v = 1'b0;
    endtask

    task automatic t_reset();
        load_plain();
        do_reset(1'b0);
        @(negedge clk);
        check(fetch_req == 1'b1, "R1 fetch_req after reset", 32'(fetch_req), 32'd1);
        check(fetch_addr == 32'h0, "R1 fetch_addr after reset", fetch_addr, 32'h0);
        check(issue_valid == 1'b0, "R1 issue_valid after reset", 32'(issue_valid), 32'd0);
    endtask

    task automatic t_linear();
        load_plain();
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) exp_a[i] = i * 4;
        check_seq("R2 linear order", 8);
    endtask

    task automatic t_full();
        load_plain();
        do_reset(1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(fetch_req == 1'b0, "R3 fetch stalls when full", 32'(fetch_req), 32'd0);
        @(posedge clk); #1 issue_ready = 1'b1;
        for (int i = 0; i < 8; i++) exp_a[i] = i * 4;
        check_seq("R3 no loss after full", 8);
    endtask

    task automatic t_uncond();
        load_plain();
        prog[2]  = jump(24'd5);
        prog[10] = jump(24'hFFFFFA);
        do_reset(1'b1);
        exp_a[0] = 0;  exp_a[1] = 4;  exp_a[2] = 28; exp_a[3] = 32; exp_a[4] = 36;
        exp_a[5] = 16; exp_a[6] = 20; exp_a[7] = 24; exp_a[8] = 28; exp_a[9] = 32;
        check_seq("R5/R11 jump folding and stale discard", 10);
    endtask

    task automatic t_cond_now();
        load_plain();
        prog[2] = cjump(1'b0, 24'd4);
        cond_busy = 1'b0;
        cond_value = 1'b1;
        do_reset(1'b1);
        exp_a[0] = 0; exp_a[1] = 4; exp_a[2] = 24; exp_a[3] = 28; exp_a[4] = 32;
        check_seq("R6 settled condition taken", 5);

        load_plain();
        prog[2] = cjump(1'b1, 24'd4);
        cond_value = 1'b0;
        do_reset(1'b1);
        exp_a[0] = 0; exp_a[1] = 4; exp_a[2] = 12; exp_a[3] = 16; exp_a[4] = 20;
        check_seq("R6 settled condition not taken", 5);
    endtask

    task automatic t_pred_ok();
        load_plain();
        prog[2] = cjump(1'b1, 24'd4);
        cond_busy = 1'b1;
        cond_value = 1'b0;
        do_reset(1'b1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(log_n == 2, "R8 speculative words held", 32'(log_n), 32'd2);
        check(issue_valid == 1'b0, "R8 issue_valid low while unresolved", 32'(issue_valid), 32'd0);
        pulse_resolve(1'b1);
        cond_busy = 1'b0;
        @(negedge clk);
        check(issue_valid == 1'b1, "R9 held word offered next cycle", 32'(issue_valid), 32'd1);
        check(issue_instr == plain(24), "R9 held word is predicted target", issue_instr, plain(24));
        exp_a[0] = 0; exp_a[1] = 4; exp_a[2] = 24; exp_a[3] = 28; exp_a[4] = 32; exp_a[5] = 36;
        check_seq("R7/R9 predicted path issued in order", 6);
    endtask

    task automatic t_pred_bad();
        load_plain();
        prog[2] = cjump(1'b1, 24'd4);
        cond_busy = 1'b1;
        do_reset(1'b1);
        repeat (20) @(posedge clk);
        pulse_resolve(1'b0);
        cond_busy = 1'b0;
        @(negedge clk);
        check(fetch_req && fetch_addr == 32'd12, "R10 fetch restarts on other path", fetch_addr, 32'd12);
        check(issue_valid == 1'b0, "R10 issue stage flushed", 32'(issue_valid), 32'd0);
        exp_a[0] = 0; exp_a[1] = 4; exp_a[2] = 12; exp_a[3] = 16; exp_a[4] = 20;
        check_seq("R10 wrong-path words discarded", 5);
    endtask

    task automatic t_second();
        load_plain();
        prog[2] = cjump(1'b0, 24'd4);
        prog[4] = cjump(1'b1, 24'd2);
        cond_busy = 1'b1;
        cond_value = 1'b1;
        do_reset(1'b1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(fetch_req == 1'b0, "R12 fetch parked on second branch", 32'(fetch_req), 32'd0);
        check(issue_valid == 1'b0, "R8 fall-through word held", 32'(issue_valid), 32'd0);
        check(log_n == 2, "R12 nothing issued past prediction", 32'(log_n), 32'd2);
        @(posedge clk); #1;
        cond_busy = 1'b0;
        res_v = 1'b1;
        res_t = 1'b0;
        @(posedge clk); #1;
        res_v = 1'b0;
        @(negedge clk);
        check(fetch_req && fetch_addr == 32'd16, "R12 refetch at parked branch", fetch_addr, 32'd16);
        exp_a[0] = 0; exp_a[1] = 4; exp_a[2] = 12; exp_a[3] = 24; exp_a[4] = 28;
        check_seq("R12 second branch handled after resolve", 5);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_linear();
                t_full();
                t_uncond();
                t_cond_now();
                t_pred_ok();
                t_pred_bad();
                t_second();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule